// File: doc/BRIEF.md
# Shared-Pin Two-Wire / SPI Register Access Front End

This block sits between a set of host-facing pins and a byte-wide register file. It lets a host read and write the registers over one of two serial protocols. After any reset it answers as a two-wire (I2C-style) slave. It switches to a four-wire SPI slave the first time the select input goes low, and it keeps that choice until the next reset. The two protocols share the clock pin and the data pin. One address-select input doubles as the SPI serial output, so the block exports an output value and an enable for that pad.

Both engines share one byte pointer. That pointer is loaded from the first byte of a transaction and steps by one after every byte moved in either direction. The block samples all pins with its own system clock, which must run more than eight times faster than the bus. Edges and bus conditions are found by comparing successive sampled values. The register file sits outside the block and is reached through a write strobe and a combinational read-data return.

Top module: `dual_serial_regif`

## Requirements
- R1: While either `rst_n` or `por_n` is low, and directly after both rise, the block is in two-wire mode: `spi_mode`=0, `so_oe`=0, `sda_oe`=0, `reg_we`=0.
- R2: While `cs_n` stays high the block stays in two-wire mode. A high-to-low change on `cs_n` sets `spi_mode`=1, which then holds whatever `cs_n` does until the next reset.
- R3: In two-wire mode the 7-bit slave address is {ADDR_HI, `sa1_in`, `sa0_in`}, sent MSB first and followed by the R/W bit (0 = write). A matching address is acknowledged by pulling the data line low in the ninth bit. A mismatched address gets no acknowledge, and every byte after it is ignored until the next START.
- R4: Two-wire write: after the address, the first byte loads the pointer. Each following data byte is acknowledged, written at the pointer, and the pointer then steps by one, wrapping from 0xFF to 0x00.
- R5: Two-wire read: after a pointer write, a repeated START and the address with R/W=1, the block returns bytes MSB first from consecutive addresses starting at the pointer. A master acknowledge (line low) asks for the next byte, and a not-acknowledge ends the read.
- R6: The data line is only ever pulled low (`sda_oe`=1 means drive 0), and only in two-wire mode. In two-wire mode it changes only while the sampled clock is low.
- R7: SPI frames use mode 0 (sample on the rising clock, MSB first). In the first byte, bit 7 is 1 for a read and 0 for a write, and bits 6..0 give the register address. In a write frame each further byte is written at consecutive addresses.
- R8: In an SPI read frame the bytes after the command byte are shifted out on `so_out` from consecutive addresses, starting at the commanded one. `so_out` changes only after falling clock edges.
- R9: `so_oe` is 1 only in SPI mode while `cs_n` is low. In SPI mode, two-wire traffic causes no acknowledge and no register write.
- R10: Each register write is a single-cycle `reg_we` pulse, and `reg_addr` is one higher in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than 8x the bus rate |
| rst_n | input | 1 | External reset, active low |
| por_n | input | 1 | Power-on reset, active low |
| scl_sck | input | 1 | Two-wire clock / SPI clock |
| sda_si | input | 1 | Two-wire data line value / SPI serial input |
| sda_oe | output | 1 | Pull the two-wire data line low |
| sa0_in | input | 1 | Address select bit 0 (two-wire mode) |
| sa1_in | input | 1 | Address select bit 1 (two-wire mode) |
| so_out | output | 1 | SPI serial output value for the shared pad |
| so_oe | output | 1 | SPI serial output enable |
| cs_n | input | 1 | Mode switch trigger / SPI select, active low |
| spi_mode | output | 1 | 1 once SPI mode is latched |
| reg_addr | output | 8 | Register pointer |
| reg_wdata | output | 8 | Register write data |
| reg_we | output | 1 | Register write strobe |
| reg_rdata | input | 8 | Register read data at `reg_addr` |

## Verification
The bench builds the block with ADDR_HI = 5'b10011 instead of the default. That value puts ones in the top and bottom fixed address bits, so a wrong bit order or a shifted comparison would miss the match. The bench drives the address-select inputs through two settings. It also flips the sa0 bit in one transaction, which brings the mismatch-and-ignore path into reach. A pointer start of 0xFE brings the wrap to 0x00 into reach for both writes and reads.

// File: rtl/dual_serial_regif.sv
module dual_serial_regif #(
  parameter logic [4:0] ADDR_HI = 5'b01010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       por_n,
  input  logic       scl_sck,
  input  logic       sda_si,
  output logic       sda_oe,
  input  logic       sa0_in,
  input  logic       sa1_in,
  output logic       so_out,
  output logic       so_oe,
  input  logic       cs_n,
  output logic       spi_mode,
  output logic [7:0] reg_addr,
  output logic [7:0] reg_wdata,
  output logic       reg_we,
  input  logic [7:0] reg_rdata
);
  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_PTR, S_WR, S_ACK, S_RD, S_MACK} st_t;

  logic       arst_n;
  logic [2:0] scl_s, sda_s, cs_s;
  logic       scl_q, scl_p, sda_q, sda_p, cs_q, cs_p;
  logic       scl_rise, scl_fall, start_c, stop_c, cs_fall;
  st_t        state, nxt;
  logic [3:0] bitcnt;
  logic [7:0] sh, ptr, wd, tx, rx_byte;
  logic       rw, first, mack, we_q, spi, addr_hit;

  assign arst_n = rst_n & por_n;
  assign scl_q = scl_s[1];
  assign scl_p = scl_s[2];
  assign sda_q = sda_s[1];
  assign sda_p = sda_s[2];
  assign cs_q  = cs_s[1];
  assign cs_p  = cs_s[2];
  assign scl_rise = scl_q & ~scl_p;
  assign scl_fall = ~scl_q & scl_p;
  assign start_c  = scl_q & scl_p & sda_p & ~sda_q;
  assign stop_c   = scl_q & scl_p & ~sda_p & sda_q;
  assign cs_fall  = cs_p & ~cs_q;
  assign rx_byte  = {sh[6:0], sda_q};
  assign addr_hit = (sh[7:1] == {ADDR_HI, sa1_in, sa0_in});

  assign sda_oe    = ~spi & ((state == S_ACK) | ((state == S_RD) & ~sh[7]));
  assign so_oe     = spi & ~cs_q;
  assign so_out    = tx[7];
  assign spi_mode  = spi;
  assign reg_addr  = ptr;
  assign reg_wdata = wd;
  assign reg_we    = we_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      scl_s <= '1;
      sda_s <= '1;
      cs_s  <= '1;
    end else begin
      scl_s <= {scl_s[1:0], scl_sck};
      sda_s <= {sda_s[1:0], sda_si};
      cs_s  <= {cs_s[1:0], cs_n};
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state <= S_IDLE;
      nxt <= S_IDLE;
      bitcnt <= '0;
      sh <= '0;
      ptr <= '0;
      wd <= '0;
      tx <= '0;
      rw <= 1'b0;
      first <= 1'b1;
      mack <= 1'b0;
      we_q <= 1'b0;
      spi <= 1'b0;
    end else begin
      we_q <= 1'b0;
      if (we_q) ptr <= ptr + 8'd1;
      if (cs_fall) spi <= 1'b1;
      if (spi || cs_fall) begin
        if (cs_q || cs_fall) begin
          bitcnt <= '0;
          first <= 1'b1;
          tx <= '0;
        end else if (scl_rise) begin
          sh <= rx_byte;
          bitcnt <= (bitcnt == 4'd7) ? 4'd0 : bitcnt + 4'd1;
          if (bitcnt == 4'd7) begin
            if (first) begin
              rw <= rx_byte[7];
              ptr <= {1'b0, rx_byte[6:0]};
              first <= 1'b0;
            end else if (!rw) begin
              we_q <= 1'b1;
              wd <= rx_byte;
            end
          end
        end else if (scl_fall) begin
          if (!first && rw && bitcnt == 4'd0) begin
            tx <= reg_rdata;
            ptr <= ptr + 8'd1;
          end else begin
            tx <= {tx[6:0], 1'b0};
          end
        end
      end else if (start_c) begin
        state <= S_ADDR;
        bitcnt <= '0;
      end else if (stop_c) begin
        state <= S_IDLE;
      end else begin
        case (state)
          S_ADDR, S_PTR, S_WR: begin
            if (scl_rise) begin
              sh <= rx_byte;
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              bitcnt <= '0;
              if (state == S_ADDR) begin
                if (addr_hit) begin
                  state <= S_ACK;
                  nxt <= sh[0] ? S_RD : S_PTR;
                end else begin
                  state <= S_IDLE;
                end
              end else if (state == S_PTR) begin
                ptr <= sh;
                state <= S_ACK;
                nxt <= S_WR;
              end else begin
                wd <= sh;
                we_q <= 1'b1;
                state <= S_ACK;
                nxt <= S_WR;
              end
            end
          end
          S_ACK: begin
            if (scl_fall) begin
              state <= nxt;
              bitcnt <= '0;
              if (nxt == S_RD) begin
                sh <= reg_rdata;
                ptr <= ptr + 8'd1;
              end
            end
          end
          S_RD: begin
            if (scl_fall) begin
              if (bitcnt == 4'd7) begin
                state <= S_MACK;
                bitcnt <= '0;
              end else begin
                sh <= {sh[6:0], 1'b0};
                bitcnt <= bitcnt + 4'd1;
              end
            end
          end
          S_MACK: begin
            if (scl_rise) begin
              mack <= ~sda_q;
            end else if (scl_fall) begin
              if (mack) begin
                state <= S_RD;
                sh <= reg_rdata;
                ptr <= ptr + 8'd1;
              end else begin
                state <= S_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R2
  mode_sticky_chk: assert property (@(posedge clk) disable iff (!arst_n)
    spi_mode |=> spi_mode);
  // R2
  mode_entry_chk: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(spi_mode) |-> !cs_s[1]);
  // R6
  sda_hold_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (!spi_mode && !$stable(sda_oe)) |-> !scl_s[1]);
  // R10
  we_pulse_chk: assert property (@(posedge clk) disable iff (!arst_n)
    reg_we |=> !reg_we);
  // R10
  ptr_step_chk: assert property (@(posedge clk) disable iff (!arst_n)
    reg_we |=> (reg_addr == $past(reg_addr) + 8'd1));
endmodule

// File: tb/sim_dual_serial_regif.sv
module sim_dual_serial_regif;
  localparam logic [4:0] AHI = 5'b10011;
  localparam int H = 16;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0, por_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1, cs_n = 1'b1, sa0 = 1'b0, sa1 = 1'b1;
  logic sda_oe, so_out, so_oe, spi_mode, reg_we;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic sda_line;
  logic [7:0] mem [256];
  logic [7:0] exp_mem [256];
  logic [15:0] wq [$];
  int total = 0, bad = 0;
  string cur = "R1";

  always #2.5 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;
  assign reg_rdata = mem[reg_addr];

  dual_serial_regif #(.ADDR_HI(AHI)) u0 (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .scl_sck(scl), .sda_si(sda_line),
    .sda_oe(sda_oe), .sa0_in(sa0), .sa1_in(sa1), .so_out(so_out), .so_oe(so_oe),
    .cs_n(cs_n), .spi_mode(spi_mode), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata));

  task automatic chk(input string r, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  // scoreboard monitor: every write strobe must match the next expected item
  always begin
    @(negedge clk);
    if (rst_n && por_n && reg_we) begin
      if (wq.size() == 0) chk({cur, " R10 unexpected write"}, {reg_addr, reg_wdata}, 16'hxxxx);
      else chk({cur, " R10 write"}, {reg_addr, reg_wdata}, wq.pop_front());
      mem[reg_addr] = reg_wdata;
    end
    if (spi_mode && sda_oe) chk("R6 sda driven in SPI mode", 16'(sda_oe), 16'h0);
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] dadr(input logic rd);
    return {AHI, sa1, sa0, rd};
  endfunction

  task automatic i2c_start;
    sda_m = 1'b1; tick(Q); scl = 1'b1; tick(H);
    sda_m = 1'b0; tick(H); scl = 1'b0; tick(Q);
  endtask

  task automatic i2c_stop;
    sda_m = 1'b0; tick(Q); scl = 1'b1; tick(H); sda_m = 1'b1; tick(H);
  endtask

  task automatic i2c_wbyte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q); scl = 1'b1; tick(H); scl = 1'b0; tick(Q);
    end
    sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q);
    ack = ~sda_line;
    tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic i2c_rbyte(input logic last, output logic [7:0] b);
    sda_m = 1'b1;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      tick(Q); scl = 1'b1; tick(Q); b = {b[6:0], sda_line}; tick(Q); scl = 1'b0;
    end
    tick(2);
    sda_m = last; tick(Q); scl = 1'b1; tick(H); scl = 1'b0; tick(Q);
    sda_m = 1'b1;
  endtask

  task automatic i2c_write(input string r, input logic [7:0] p, input int n, input logic [31:0] d);
    logic ack;
    i2c_start;
    i2c_wbyte(dadr(1'b0), ack); chk({r, " R3 address ack"}, 16'(ack), 16'h1);
    i2c_wbyte(p, ack);          chk({r, " pointer ack"}, 16'(ack), 16'h1);
    for (int i = 0; i < n; i++) begin
      logic [7:0] a, v;
      a = p + 8'(i);
      v = d[8*i +: 8];
      wq.push_back({a, v});
      exp_mem[a] = v;
      i2c_wbyte(v, ack); chk({r, " data ack"}, 16'(ack), 16'h1);
    end
    i2c_stop;
    chk({r, " all writes seen"}, 16'(wq.size()), 16'h0);
  endtask

  task automatic i2c_read(input string r, input logic [7:0] p, input int n);
    logic ack;
    logic [7:0] b;
    i2c_start;
    i2c_wbyte(dadr(1'b0), ack);
    i2c_wbyte(p, ack);
    i2c_start;
    i2c_wbyte(dadr(1'b1), ack); chk({r, " R3 read address ack"}, 16'(ack), 16'h1);
    for (int i = 0; i < n; i++) begin
      logic [7:0] a;
      a = p + 8'(i);
      i2c_rbyte(i == n - 1, b);
      chk({r, " read data"}, {a, b}, {a, exp_mem[a]});
    end
    i2c_stop;
  endtask

  task automatic spi_xfer(input logic [7:0] o, output logic [7:0] in);
    in = '0;
    for (int i = 7; i >= 0; i--) begin
      sda_m = o[i]; tick(H);
      in = {in[6:0], so_out};
      scl = 1'b1; tick(H); scl = 1'b0;
    end
  endtask

  task automatic spi_write(input logic [6:0] a0, input int n, input logic [31:0] d);
    logic [7:0] in;
    cs_n = 1'b0; tick(H);
    chk("R9 so_oe in frame", 16'(so_oe), 16'h1);
    spi_xfer({1'b0, a0}, in);
    for (int i = 0; i < n; i++) begin
      logic [7:0] a;
      a = {1'b0, a0} + 8'(i);
      wq.push_back({a, d[8*i +: 8]});
      exp_mem[a] = d[8*i +: 8];
      spi_xfer(d[8*i +: 8], in);
    end
    tick(Q); cs_n = 1'b1; tick(H);
    chk("R9 so_oe after frame", 16'(so_oe), 16'h0);
    chk("R7 all writes seen", 16'(wq.size()), 16'h0);
  endtask

  task automatic spi_read(input logic [6:0] a0, input int n);
    logic [7:0] in;
    cs_n = 1'b0; tick(H);
    spi_xfer({1'b1, a0}, in);
    for (int i = 0; i < n; i++) begin
      logic [7:0] a;
      a = {1'b0, a0} + 8'(i);
      spi_xfer(8'h00, in);
      chk("R8 SPI read data", {a, in}, {a, exp_mem[a]});
    end
    chk("R6 no sda drive in SPI", 16'(sda_oe), 16'h0);
    tick(Q); cs_n = 1'b1; tick(H);
  endtask

  initial begin
    logic ack;
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'h00;
      exp_mem[i] = 8'h00;
    end
    tick(10);
    chk("R1 mode in reset", {14'd0, spi_mode, so_oe}, 16'h0);
    rst_n = 1'b1; por_n = 1'b1; tick(10);
    chk("R1 mode after reset", {13'd0, spi_mode, so_oe, sda_oe}, 16'h0);
    chk("R1 no write strobe", 16'(reg_we), 16'h0);

    cur = "R4";
    i2c_write("R4", 8'h10, 3, 32'h00C3B2A1);
    cur = "R5";
    i2c_read("R5", 8'h10, 3);
    i2c_read("R5 single", 8'h11, 1);
    cur = "R4";
    i2c_write("R4 wrap", 8'hFE, 3, 32'h00675645);
    cur = "R5";
    i2c_read("R5 wrap", 8'hFF, 2);

    cur = "R3";
    i2c_start;
    i2c_wbyte({AHI, sa1, ~sa0, 1'b0}, ack); chk("R3 mismatch nack", 16'(ack), 16'h0);
    i2c_wbyte(8'h10, ack); chk("R3 ignored pointer", 16'(ack), 16'h0);
    i2c_wbyte(8'h99, ack); chk("R3 ignored data", 16'(ack), 16'h0);
    i2c_stop;
    i2c_read("R3 unchanged after mismatch", 8'h10, 1);
    sa0 = 1'b1; sa1 = 1'b0;
    i2c_write("R3 new address", 8'h40, 2, 32'h00005A3C);
    i2c_read("R3 new address", 8'h40, 2);
    chk("R2 stays two-wire with cs_n high", 16'(spi_mode), 16'h0);

    cur = "R7";
    scl = 1'b0; tick(H);
    spi_write(7'h20, 2, 32'h00007E81);
    chk("R2 SPI latched", 16'(spi_mode), 16'h1);
    cur = "R8";
    spi_read(7'h20, 2);
    spi_read(7'h10, 3);
    spi_read(7'h7F, 1);
    chk("R2 SPI held with cs_n high", 16'(spi_mode), 16'h1);

    cur = "R9";
    sa0 = 1'b0; sa1 = 1'b1;
    i2c_start;
    i2c_wbyte(dadr(1'b0), ack); chk("R9 no ack in SPI mode", 16'(ack), 16'h0);
    i2c_wbyte(8'h10, ack);
    i2c_wbyte(8'hEE, ack);
    i2c_stop;
    scl = 1'b0; tick(H);
    spi_read(7'h10, 1);
    chk("R2 SPI held after two-wire traffic", 16'(spi_mode), 16'h1);

    cur = "R1";
    por_n = 1'b0; tick(4);
    chk("R1 power-on reset", {14'd0, spi_mode, so_oe}, 16'h0);
    por_n = 1'b1; scl = 1'b1; sda_m = 1'b1; tick(H);
    chk("R1 two-wire after power-on reset", 16'(spi_mode), 16'h0);
    i2c_read("R1 R5 read after reset", 8'h20, 2);
    scl = 1'b0; tick(H);
    cur = "R7";
    spi_write(7'h05, 1, 32'h000000D4);
    rst_n = 1'b0; tick(4); rst_n = 1'b1; scl = 1'b1; tick(H);
    chk("R1 external reset", 16'(spi_mode), 16'h0);
    cur = "R5";
    i2c_read("R5 after external reset", 8'h05, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule